// File: doc/BRIEF.md
# Keyboard Character Latch Port

This block sits between a keyboard decoder running on a slow clock and a CPU that polls an 8-bit I/O port on the fast system clock. The decoder signals each key event with a ready level that stays high for many fast cycles, together with a 7-bit character code and a release flag. The block samples that ready level into a short history every fast cycle. It stores the character exactly once per event, when the history shows a run of low samples followed by a run of high samples.

The CPU reads the stored character through a port address. The read strobe is taken from the rising edge of the CPU read level, so a read level held for many cycles counts as a single read. A read returns the stored value and then empties the store. If a new event qualifies in that same cycle, the new event is kept rather than cleared. A stored value of zero means no key is waiting. Releases carry the key code with bit 7 set, so software that discards values above 127 sees only presses.

A parameter selects the qualifying window. The standard window is eight samples: four low, then four high. The short window is six samples: three low, then three high. The short window suits ready pulses that are too narrow for the standard one.

Top module: `kbd_char_port`

## Requirements
- R1: After reset, the read data output is 0x00 and no character is stored, so the first read returns 0x00.
- R2: The ready input is shifted into the history at the least significant end every clock. With the standard window, a character is stored in the cycle after the history equals 00001111 (four low samples, then four high samples). It is stored once per event, however long ready stays high.
- R3: A ready pulse of fewer high samples than the window's half, or one preceded by fewer low samples than the half, stores nothing.
- R4: With the short window selected, the qualifying pattern is the low 6 history bits equal to 000111. A pulse of three high samples after three or more lows then stores a character, which the standard window would reject.
- R5: A read is a rising edge of the read input while the address equals the port address. In the cycle after a read, the read data output holds the value stored before that read. It keeps that value until the next read.
- R6: A rising read edge at any other address changes neither the read data output nor the stored character.
- R7: After a read, the stored character becomes 0x00, so an immediate second read returns 0x00.
- R8: If a read and a qualifying pattern fall in the same cycle, the read returns the old value and the new character stays stored.
- R9: The stored byte has the release flag in bit 7 and the 7-bit key code in bits 6:0. A press of code 0x41 reads 0x41, and its release reads 0xC1.
- R10: A read level held high for many cycles performs only one read. A character that qualifies during that time stays stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_rdy | input | 1 | Ready level from the slow keyboard decoder |
| key_code | input | 7 | Character code from the decoder |
| key_up | input | 1 | Release flag from the decoder, 1 for key release |
| cpu_rd | input | 1 | Synchronized CPU I/O read level |
| cpu_addr | input | ADDR_W | CPU I/O address |
| rd_data | output | 8 | Port read data, updated in the cycle after a read |

## Verification
The assertions assume that the key code and release flag are stable while the ready level is high around the qualifying edge. They also assume the read level and address are already synchronous to the fast clock. The stimulus drives every input at the falling edge and holds each event's code for its whole ready pulse. It draws low and high run lengths at random from one to ten cycles, so both qualifying and rejected pulses occur. Reads are random levels with a mix of matching and foreign addresses. Directed cases place a read edge exactly on the qualifying cycle and hold a read level across a whole key event.

// File: rtl/kbd_char_port.sv
module kbd_char_port #(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h4C,
  parameter bit              SHORT_QUAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_rdy,
  input  logic [6:0]        key_code,
  input  logic              key_up,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [7:0]        rd_data
);
  localparam int HIST_W = 8;
  localparam int QW     = SHORT_QUAL ? 6 : 8;
  localparam logic [QW-1:0] PAT = {{(QW/2){1'b0}}, {(QW/2){1'b1}}};

  logic [HIST_W-1:0] hist;
  logic [7:0]        held;
  logic              rd_q;
  logic              match;
  logic              rd_fire;

  assign match   = (hist[QW-1:0] == PAT);
  assign rd_fire = cpu_rd & ~rd_q & (cpu_addr == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      rd_q <= 1'b0;
    end else begin
      hist <= {hist[HIST_W-2:0], key_rdy};
      rd_q <= cpu_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      rd_data <= '0;
    end else begin
      if (rd_fire) rd_data <= held;
      if (match)        held <= {key_up, key_code};
      else if (rd_fire) held <= '0;
    end
  end
endmodule

// File: rtl/kbd_char_port_chk.sv
module kbd_char_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_fire,
  input logic       match,
  input logic [7:0] held,
  input logic [7:0] rd_data,
  input logic [7:0] key_in
);
  // R5
  read_returns_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_data == $past(held));
  // R6
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !match) |=> held == 8'h00);
  // R8
  new_key_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> held == $past(key_in));
  // R2
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !rd_fire) |=> $stable(held));
  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_fire);
  // R2
  single_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);
endmodule

bind kbd_char_port kbd_char_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .match(match),
  .held(held), .rd_data(rd_data), .key_in({key_up, key_code})
);

// File: tb/kbd_char_port_test.sv
module kbd_char_port_test;
  localparam logic [7:0] PA = 8'h4C;
  logic clk = 1'b0, rst_n = 1'b0, key_rdy = 1'b0, key_up = 1'b0, cpu_rd = 1'b0;
  logic [6:0] key_code = '0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] rd_l, rd_s;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_char_port #(.ADDR_W(8), .PORT_ADDR(PA), .SHORT_QUAL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .key_rdy(key_rdy), .key_code(key_code), .key_up(key_up),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .rd_data(rd_l));
  kbd_char_port #(.ADDR_W(8), .PORT_ADDR(PA), .SHORT_QUAL(1'b1)) uut_short (
    .clk(clk), .rst_n(rst_n), .key_rdy(key_rdy), .key_code(key_code), .key_up(key_up),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .rd_data(rd_s));

  logic [7:0] h_l, h_s, hist_l, hist_s, e_l, e_s;
  logic m_rdq;

  function automatic logic qual(logic [7:0] h, bit s);
    return s ? (h[5:0] == 6'b000111) : (h == 8'h0F);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic rdy, input logic up, input logic [6:0] code,
                      input logic rd, input logic [7:0] addr, input string tag);
    logic fire;
    key_rdy = rdy; key_up = up; key_code = code; cpu_rd = rd; cpu_addr = addr;
    @(posedge clk);
    fire = rd & ~m_rdq & (addr == PA);
    if (fire) begin e_l = h_l; e_s = h_s; end
    if (qual(hist_l, 0)) h_l = {up, code}; else if (fire) h_l = 8'h00;
    if (qual(hist_s, 1)) h_s = {up, code}; else if (fire) h_s = 8'h00;
    hist_l = {hist_l[6:0], rdy};
    hist_s = {hist_s[6:0], rdy};
    m_rdq = rd;
    @(negedge clk);
    check({tag, " std"}, rd_l, e_l);
    check({tag, " short"}, rd_s, e_s);
  endtask

  task automatic key_event(input logic up, input logic [6:0] code, input int lows,
                           input int highs, input string tag);
    for (int i = 0; i < lows; i++) step(1'b0, up, code, 1'b0, PA, tag);
    for (int i = 0; i < highs; i++) step(1'b1, up, code, 1'b0, PA, tag);
  endtask

  task automatic read_port(input logic [7:0] addr, input string tag);
    step(1'b0, 1'b0, 7'h0, 1'b1, addr, tag);
    step(1'b0, 1'b0, 7'h0, 1'b0, addr, tag);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    h_l = 0; h_s = 0; hist_l = 0; hist_s = 0; e_l = 0; e_s = 0; m_rdq = 0;
    repeat (3) @(negedge clk);
    check("R1 reset std", rd_l, 8'h00);
    check("R1 reset short", rd_s, 8'h00);
    rst_n = 1'b1;
    read_port(PA, "R1 empty read");
    // R2 R5 R7
    key_event(1'b0, 7'h41, 8, 12, "R2 press");
    key_event(1'b0, 7'h41, 4, 0, "R2 gap");
    read_port(PA, "R5 read press");
    check("R5 press value", rd_l, 8'h41);
    read_port(PA, "R7 second read");
    check("R7 cleared", rd_l, 8'h00);
    // R9
    key_event(1'b1, 7'h41, 6, 6, "R9 release");
    read_port(PA, "R9 read release");
    check("R9 release value", rd_l, 8'hC1);
    // R3 R4
    key_event(1'b0, 7'h12, 8, 2, "R3 narrow");
    key_event(1'b0, 7'h13, 2, 6, "R3 short low");
    key_event(1'b0, 7'h14, 6, 3, "R4 three high");
    key_event(1'b0, 7'h14, 6, 0, "R4 gap");
    read_port(PA, "R4 read");
    check("R3 R4 std rejects", rd_l, 8'h00);
    check("R4 short accepts", rd_s, 8'h14);
    // R6
    key_event(1'b0, 7'h22, 8, 8, "R6 press");
    read_port(8'h4D, "R6 foreign read");
    check("R6 untouched", rd_l, 8'h00);
    read_port(PA, "R6 real read");
    check("R6 still held", rd_l, 8'h22);
    // R8 collision: old char pending, read edge on qualifying cycle
    key_event(1'b0, 7'h22, 8, 8, "R8 old");
    key_event(1'b0, 7'h33, 8, 4, "R8 lead");
    step(1'b1, 1'b0, 7'h33, 1'b1, PA, "R8 collide");
    check("R8 old returned", rd_l, 8'h22);
    step(1'b1, 1'b0, 7'h33, 1'b0, PA, "R8 after");
    read_port(PA, "R8 read new");
    check("R8 new kept", rd_l, 8'h33);
    // R10 long read level across an event
    step(1'b0, 1'b0, 7'h55, 1'b1, PA, "R10 hold");
    for (int i = 0; i < 16; i++) step(i >= 6, 1'b0, 7'h55, 1'b1, PA, "R10 hold");
    step(1'b0, 1'b0, 7'h55, 1'b0, PA, "R10 drop");
    read_port(PA, "R10 read");
    check("R10 kept", rd_l, 8'h55);
    // random mix
    for (int n = 0; n < 2500; n++) begin
      int lo, hi;
      logic up;
      logic [6:0] code;
      lo = 1 + ($urandom % 10); hi = 1 + ($urandom % 10);
      up = $urandom % 2; code = 7'($urandom);
      for (int i = 0; i < lo + hi; i++)
        step(i >= lo, up, code, ($urandom % 4) == 0,
             (($urandom % 4) == 0) ? 8'($urandom) : PA, "R2 R5 R8 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule